// File: doc/BRIEF.md
# Single-Byte Register-Controlled I2C Master

This block is the only master on a two-wire bus. It runs one complete byte transfer to an addressed device, which can be a write or a random-access read. Software sets up the transfer in registers first. A command register holds the 7-bit device address, the device-internal byte address and a direction flag. A transmit register holds the data byte for a write. Software then sets the launch bit in the control/status register and polls that register until the launch bit drops.

Every transfer carries a byte address. A write sends the start condition, the device address with a write bit, the byte address, the data byte and a stop. A read sends the start condition, the device address with a write bit and the byte address. It then sends a repeated start and the device address with a read bit, receives one byte, answers it with a not-acknowledge and ends with a stop. Software checks whether a device is present by reading internal address 0.

The SCL rate is fixed by a parameter. Both pins are open-drain: each output enable pulls its line low. The engine state machine has these states and transitions:
- IDLE goes to START on a launch, or straight to DONE when the size or lane field is bad.
- START covers four quarter-periods. From idle it enters at its third quarter. It moves on to BIT.
- BIT repeats nine times per byte. After the ninth bit it goes to BIT for the next byte, to START for the repeated start, or to STOP.
- STOP goes to DONE.
- DONE goes to IDLE.
- A bus timeout in START, BIT or STOP goes straight to DONE.

Top module: `i2cb_master`

## Requirements
- R1: After reset the control/status register reads 0, and neither line is driven. Whenever the launch bit (status bit 0) is clear, neither line is driven.
- R2: The command register reads back as written. Its fields are: byte address in bits [23:16], direction flag in bit 12 (1 = write, 0 = read), device address bits [2:0] in bits [10:8], and device address bits [6:3] in bits [3:0].
- R3: Writing 1 to bit 0 of the control/status register (offset 1) while idle launches a transfer. Bit 0 stays 1 until the transfer ends, then clears by itself. While the transfer runs, bit 1 is set for a read and bit 2 is set for a write, never both.
- R4: While bit 0, 1 or 2 is set, any write to the control/status register is ignored. It changes neither the size field nor the lane field, and it launches nothing.
- R5: A write sends the device address with R/W=0, the byte address, and the low 8 bits of the transmit register (offset 2), then a stop. The device stores the byte at that address.
- R6: A read sends the device address with R/W=0 and the byte address, then a repeated start and the device address with R/W=1. The received byte appears in bits [7:0] of the receive register (offset 3).
- R7: A missing acknowledge after any address or written data byte sets the configuration-error flag (bit 3). The master then sends a stop and ends the transfer.
- R8: A launch with a nonzero size field (bits [9:8]) or lane field (bits [11:10]) sets bit 3 and ends the transfer with no SCL activity.
- R9: If SCL is held low for TO_LIMIT clock cycles while the master has released it, the timeout-error flag (bit 4) is set. Both lines are released and the transfer ends.
- R10: If SCL is held low for fewer than TO_LIMIT cycles, the transfer is only delayed. It completes without error.
- R11: After the received byte of a read, the master answers with a not-acknowledge.
- R12: Each launch clears both error flags. A successful transfer leaves bits 3 and 4 at 0.
- R13: Only bits [7:0] of the transmit register are sent. Higher bits written there have no effect on the byte on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write register offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read register offset |
| reg_rdata | output | 32 | Read data (combinational) |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check on every cycle that the read and write busy flags are never both set, and that a busy flag never appears without the launch bit. They also check that the lines are released whenever no transfer is pending, that writes while busy leave the size and lane fields alone, that a launch clears or sets the error flags as its size and lane fields demand, and that a timeout leaves both lines released. Only the bench scenarios can show the rest. These are the byte order on the wire and the repeated start, the data stored and returned for many addresses, and the not-acknowledge after read data. They also include error detection for each device-address bit across both split fields, and how the block responds to short and long clock stretching.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    // Register offsets
    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_CTL  = 2'd1;
    localparam logic [1:0] OFS_TXD  = 2'd2;
    localparam logic [1:0] OFS_RXD  = 2'd3;

    // Command register fields
    localparam int CMD_WR_BIT   = 12;
    localparam int CMD_BA_LSB   = 16;
    localparam int CMD_DLO_LSB  = 8;

    // Control/status register fields
    localparam int CTL_GO       = 0;
    localparam int CTL_SIZE_LSB = 8;
    localparam int CTL_LANE_LSB = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP,
        ST_DONE
    } eng_state_t;

    typedef enum logic [2:0] {
        STEP_DEVW,
        STEP_BADDR,
        STEP_WDATA,
        STEP_DEVR,
        STEP_RDATA
    } step_t;

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
    parameter int QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(QTR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
    import i2cb_pkg::*;
#(
    parameter int QTR      = 4,
    parameter int TO_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       bad_cfg,
    input  logic [6:0] dev,
    input  logic [7:0] baddr,
    input  logic [7:0] wdata,
    input  logic       wr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic       is_wr,
    output logic       cfg_err,
    output logic       to_err,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    localparam int SW = $clog2(TO_LIMIT + 1);

    eng_state_t state, state_n;
    step_t      step, step_n;
    logic [1:0] ph, ph_n;
    logic [3:0] bc, bc_n;
    logic [6:0] dev_q;
    logic [7:0] baddr_q, wdata_q, rx_sh, rx_n, tx_byte;
    logic       wr_q, sda_q, sda_n, cfg_q, cfg_n, to_q, to_n;
    logic [SW-1:0] str_cnt;
    logic       active, tick, adv, stretching, to_hit, bit_oe;

    i2cb_qtick #(.QTR(QTR)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .tick (tick)
    );

    assign active     = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
    assign stretching = active && (ph == 2'd2) && !scl_in;
    assign to_hit     = stretching && (str_cnt == SW'(TO_LIMIT - 1));
    assign adv        = tick && ((ph != 2'd2) || scl_in);

    always_comb begin
        unique case (step)
            STEP_DEVW:  tx_byte = {dev_q, 1'b0};
            STEP_BADDR: tx_byte = baddr_q;
            STEP_WDATA: tx_byte = wdata_q;
            STEP_DEVR:  tx_byte = {dev_q, 1'b1};
            default:    tx_byte = 8'hFF;
        endcase
        bit_oe = (bc < 4'd8) ? ~tx_byte[~bc[2:0]] : 1'b0;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        step_n  = step;
        ph_n    = ph;
        bc_n    = bc;
        sda_n   = sda_q;
        cfg_n   = cfg_q;
        to_n    = to_q;
        rx_n    = rx_sh;
        unique case (state)
            ST_IDLE: if (go) begin
                cfg_n  = bad_cfg;
                to_n   = 1'b0;
                step_n = STEP_DEVW;
                bc_n   = '0;
                ph_n   = 2'd2;
                state_n = bad_cfg ? ST_DONE : ST_START;
            end
            ST_START: if (adv) begin
                ph_n = ph + 2'd1;
                if (ph == 2'd0) sda_n = 1'b0;
                if (ph == 2'd2) sda_n = 1'b1;
                if (ph == 2'd3) state_n = ST_BIT;
            end
            ST_BIT: if (adv) begin
                ph_n = ph + 2'd1;
                if (ph == 2'd0) sda_n = bit_oe;
                if (ph == 2'd3) begin
                    if (bc < 4'd8) begin
                        if (step == STEP_RDATA) rx_n = {rx_sh[6:0], sda_in};
                        bc_n = bc + 4'd1;
                    end else begin
                        bc_n = '0;
                        if (step != STEP_RDATA && sda_in) begin
                            cfg_n   = 1'b1;
                            state_n = ST_STOP;
                        end else begin
                            unique case (step)
                                STEP_DEVW:  step_n = STEP_BADDR;
                                STEP_BADDR: begin
                                    step_n = wr_q ? STEP_WDATA : STEP_DEVR;
                                    if (!wr_q) state_n = ST_START;
                                end
                                STEP_DEVR:  step_n = STEP_RDATA;
                                default:    state_n = ST_STOP;
                            endcase
                        end
                    end
                end
            end
            ST_STOP: if (adv) begin
                ph_n = ph + 2'd1;
                if (ph == 2'd0) sda_n = 1'b1;
                if (ph == 2'd3) begin
                    sda_n   = 1'b0;
                    state_n = ST_DONE;
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
        if (to_hit) begin
            to_n    = 1'b1;
            sda_n   = 1'b0;
            state_n = ST_DONE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= STEP_DEVW;
            ph      <= '0;
            bc      <= '0;
            sda_q   <= 1'b0;
            cfg_q   <= 1'b0;
            to_q    <= 1'b0;
            rx_sh   <= '0;
            dev_q   <= '0;
            baddr_q <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            str_cnt <= '0;
        end else begin
            state   <= state_n;
            step    <= step_n;
            ph      <= ph_n;
            bc      <= bc_n;
            sda_q   <= sda_n;
            cfg_q   <= cfg_n;
            to_q    <= to_n;
            rx_sh   <= rx_n;
            str_cnt <= stretching ? str_cnt + 1'b1 : '0;
            if (state == ST_IDLE && go) begin
                dev_q   <= dev;
                baddr_q <= baddr;
                wdata_q <= wdata;
                wr_q    <= wr;
            end
        end
    end

    // Outputs
    always_comb begin
        scl_oe   = active && (ph < 2'd2);
        sda_oe   = sda_q;
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        is_wr    = wr_q;
        cfg_err  = cfg_q;
        to_err   = to_q;
        rx_valid = (state == ST_DONE) && !wr_q && !cfg_q && !to_q;
        rx_byte  = rx_sh;
    end
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
    import i2cb_pkg::*;
#(
    parameter int QTR      = 125,
    parameter int TO_LIMIT = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    logic [31:0] cmd_q;
    logic [7:0]  txd_q, rxd_q, rx_byte;
    logic [1:0]  size_q, lane_q;
    logic        go_q, busy_any, launch, ctl_wr, bad_cfg;
    logic        eng_busy, eng_done, eng_wr, eng_cfg, eng_to, rx_valid;
    logic [31:0] ctl_view;

    assign busy_any = go_q || eng_busy;
    assign ctl_wr   = reg_wr && (reg_addr == OFS_CTL) && !busy_any;
    assign launch   = ctl_wr && reg_wdata[CTL_GO];
    assign bad_cfg  = (reg_wdata[CTL_SIZE_LSB +: 2] != 2'd0) ||
                      (reg_wdata[CTL_LANE_LSB +: 2] != 2'd0);

    i2cb_engine #(.QTR(QTR), .TO_LIMIT(TO_LIMIT)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (launch),
        .bad_cfg (bad_cfg),
        .dev     ({cmd_q[3:0], cmd_q[CMD_DLO_LSB +: 3]}),
        .baddr   (cmd_q[CMD_BA_LSB +: 8]),
        .wdata   (txd_q),
        .wr      (cmd_q[CMD_WR_BIT]),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .busy    (eng_busy),
        .done    (eng_done),
        .is_wr   (eng_wr),
        .cfg_err (eng_cfg),
        .to_err  (eng_to),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            txd_q  <= '0;
            rxd_q  <= '0;
            size_q <= '0;
            lane_q <= '0;
            go_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_CMD) cmd_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_TXD) txd_q <= reg_wdata[7:0];
            if (ctl_wr) begin
                size_q <= reg_wdata[CTL_SIZE_LSB +: 2];
                lane_q <= reg_wdata[CTL_LANE_LSB +: 2];
            end
            if (launch)        go_q <= 1'b1;
            else if (eng_done) go_q <= 1'b0;
            if (rx_valid) rxd_q <= rx_byte;
        end
    end

    assign ctl_view = {20'd0, lane_q, size_q, 3'd0, eng_to, eng_cfg,
                       eng_busy && eng_wr, eng_busy && !eng_wr, go_q};

    always_comb begin
        unique case (reg_raddr)
            OFS_CMD: reg_rdata = cmd_q;
            OFS_CTL: reg_rdata = ctl_view;
            OFS_TXD: reg_rdata = {24'd0, txd_q};
            default: reg_rdata = {24'd0, rxd_q};
        endcase
    end
endmodule

// File: rtl/i2cb_master_chk.sv
module i2cb_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctl,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        reg_wr,
    input logic [1:0]  reg_addr
);
    a_r1_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[0] |-> (!scl_oe && !sda_oe));

    a_r3_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl[1] && ctl[2]));

    a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1] || ctl[2]) |-> ctl[0]);

    a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[0] && reg_wr && reg_addr == 2'd1) |=> $stable(ctl[11:8]));

    a_r8_launch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl[0]) |-> (!ctl[4] && (ctl[3] == (ctl[11:8] != 4'd0))));

    a_r9_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl[4]) |-> (!scl_oe && !sda_oe));
endmodule

bind i2cb_master i2cb_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl_view),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr)
);

// File: tb/i2cb_master_tb.sv
module i2cb_master_tb;
    localparam int QTR = 4;
    localparam int TO_LIMIT = 64;
    localparam logic [6:0] SLV_DEV = 7'h53;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic scl_oe, sda_oe, scl_w, sda_w;
    logic hold_scl = 1'b0;
    logic slv_sda_low = 1'b0;

    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign scl_w = !(scl_oe || hold_scl);
    assign sda_w = !(sda_oe || slv_sda_low);

    i2cb_master #(.QTR(QTR), .TO_LIMIT(TO_LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // Behavioural byte-addressed slave device
    typedef enum int {M_IDLE, M_ADDR, M_REG, M_WDATA, M_RDATA} smode_t;
    smode_t mode = M_IDLE, nxt = M_IDLE;
    logic [7:0] mem [256];
    logic [7:0] sh = '0, rsh = '0, ptr = '0;
    logic p_scl = 1'b1, p_sda = 1'b1, mst_nack = 1'b0;
    int bitn = 0, falls = 0, stops = 0;

    always @(scl_w or sda_w) begin
        if (p_scl && scl_w && p_sda && !sda_w) begin
            mode = M_ADDR; bitn = -1; slv_sda_low = 1'b0;
        end else if (p_scl && scl_w && !p_sda && sda_w) begin
            mode = M_IDLE; slv_sda_low = 1'b0; stops++;
        end else if (!p_scl && scl_w) begin
            if (mode != M_IDLE && mode != M_RDATA && bitn >= 0 && bitn < 8)
                sh = {sh[6:0], sda_w};
            else if (mode == M_RDATA && bitn == 8)
                mst_nack = sda_w;
        end else if (p_scl && !scl_w) begin
            falls++;
            if (mode != M_IDLE) begin
                bitn++;
                if (bitn == 8) begin
                    case (mode)
                        M_ADDR: if (sh[7:1] == SLV_DEV) begin
                            slv_sda_low = 1'b1;
                            nxt = sh[0] ? M_RDATA : M_REG;
                        end else mode = M_IDLE;
                        M_REG: begin ptr = sh; slv_sda_low = 1'b1; nxt = M_WDATA; end
                        M_WDATA: begin mem[ptr] = sh; ptr++; slv_sda_low = 1'b1; nxt = M_WDATA; end
                        default: begin slv_sda_low = 1'b0; nxt = M_RDATA; end
                    endcase
                end else if (bitn == 9) begin
                    bitn = 0;
                    slv_sda_low = 1'b0;
                    if (mode == M_RDATA && mst_nack) mode = M_IDLE;
                    else begin
                        mode = nxt;
                        if (mode == M_RDATA) begin
                            rsh = mem[ptr]; ptr++;
                            slv_sda_low = !rsh[7];
                        end
                    end
                end else if (mode == M_RDATA && bitn > 0 && bitn < 8) begin
                    slv_sda_low = !rsh[7 - bitn];
                end
            end
        end
        p_scl = scl_w;
        p_sda = sda_w;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rread(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            rread(2'd1, v);
            n++;
        end while (v[0] && n < 20000);
    endtask

    function automatic logic [31:0] mk_cmd(input logic [6:0] dv, input logic [7:0] ba, input logic w);
        return ({24'd0, ba} << 16) | (32'(w) << 12) | (32'(dv[2:0]) << 8) | 32'(dv[6:3]);
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 11);
    endfunction

    function automatic logic [7:0] adr(input int a);
        return 8'(a * 13 + 2);
    endfunction

    initial begin
        logic [31:0] v;
        int f0, s0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rread(2'd1, v); check("R1 ctl reset", v, 32'h0);
        check("R1 lines released", {scl_oe, sda_oe}, 2'b00);
        rread(2'd3, v); check("R1 rx reset", v, 32'h0);

        // R2 command register layout and readback
        rwrite(2'd0, mk_cmd(7'h2C, 8'hA5, 1'b1));
        rread(2'd0, v); check("R2 cmd readback", v, 32'h00A5_1405);

        // R5/R13/R3 write sweep
        for (int a = 0; a < 16; a++) begin
            rwrite(2'd2, {24'hDEAD00 + 24'(a), pat(a)});
            rwrite(2'd0, mk_cmd(SLV_DEV, adr(a), 1'b1));
            rwrite(2'd1, 32'h1);
            rread(2'd1, v); check("R3 write busy flags", v & 32'h7, 32'h5);
            wait_idle();
            rread(2'd1, v); check("R3 R12 write done status", v, 32'h0);
            check("R5 R13 stored byte", 32'(mem[adr(a)]), 32'(pat(a)));
        end

        // R6/R11/R3 read sweep
        for (int a = 0; a < 16; a++) begin
            mst_nack = 1'b0;
            rwrite(2'd0, mk_cmd(SLV_DEV, adr(15 - a), 1'b0));
            rwrite(2'd1, 32'h1);
            rread(2'd1, v); check("R3 read busy flags", v & 32'h7, 32'h3);
            wait_idle();
            rread(2'd1, v); check("R12 read done status", v, 32'h0);
            rread(2'd3, v); check("R6 received byte", v, 32'(pat(15 - a)));
            check("R11 nack after data", 32'(mst_nack), 32'h1);
        end

        // R7 wrong device address, each bit of both split fields
        for (int k = 0; k < 7; k++) begin
            s0 = stops;
            rwrite(2'd0, mk_cmd(SLV_DEV ^ 7'(1 << k), 8'h00, 1'b0));
            rwrite(2'd1, 32'h1);
            wait_idle();
            rread(2'd1, v); check("R7 nack cfg error", v, 32'h8);
            check("R7 stop issued", 32'(stops - s0), 32'h1);
            check("R7 lines released", {scl_oe, sda_oe}, 2'b00);
        end

        // R12 error cleared by next good launch
        rwrite(2'd0, mk_cmd(SLV_DEV, adr(3), 1'b0));
        rwrite(2'd1, 32'h1);
        wait_idle();
        rread(2'd1, v); check("R12 error cleared", v, 32'h0);

        // R8 bad size / lane
        f0 = falls;
        rwrite(2'd1, 32'h101);
        wait_idle();
        rread(2'd1, v); check("R8 size error", v, 32'h108);
        rwrite(2'd1, 32'h801);
        wait_idle();
        rread(2'd1, v); check("R8 lane error", v, 32'h808);
        check("R8 no scl activity", 32'(falls - f0), 32'h0);
        rwrite(2'd1, 32'h0);

        // R4 write while busy ignored
        s0 = stops;
        rwrite(2'd0, mk_cmd(SLV_DEV, adr(7), 1'b0));
        rwrite(2'd1, 32'h1);
        rwrite(2'd1, 32'hF01);
        rread(2'd1, v); check("R4 fields unchanged", v & 32'hF01, 32'h1);
        wait_idle();
        rread(2'd1, v); check("R4 status after", v, 32'h0);
        check("R4 single transfer", 32'(stops - s0), 32'h1);
        rread(2'd3, v); check("R4 data intact", v, 32'(pat(7)));

        // R10 short stretch
        rwrite(2'd0, mk_cmd(SLV_DEV, adr(9), 1'b0));
        rwrite(2'd1, 32'h1);
        repeat (30) @(posedge clk);
        @(negedge scl_w);
        hold_scl = 1'b1;
        repeat (20) @(posedge clk);
        hold_scl = 1'b0;
        wait_idle();
        rread(2'd1, v); check("R10 no error", v, 32'h0);
        rread(2'd3, v); check("R10 data", v, 32'(pat(9)));

        // R9 long stretch
        rwrite(2'd0, mk_cmd(SLV_DEV, adr(1), 1'b1));
        rwrite(2'd1, 32'h1);
        repeat (30) @(posedge clk);
        @(negedge scl_w);
        hold_scl = 1'b1;
        wait_idle();
        rread(2'd1, v); check("R9 timeout flag", v, 32'h10);
        check("R9 lines released", {scl_oe, sda_oe}, 2'b00);
        hold_scl = 1'b0;
        repeat (20) @(posedge clk);

        // R12 recovery after timeout
        rwrite(2'd0, mk_cmd(SLV_DEV, adr(2), 1'b0));
        rwrite(2'd1, 32'h1);
        wait_idle();
        rread(2'd1, v); check("R12 after timeout", v, 32'h0);
        rread(2'd3, v); check("R6 after timeout", v, 32'(pat(2)));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule